// File: doc/BRIEF.md
# Burst dimming PWM controller

This block makes the slow on/off burst signal that gates a full-bridge lamp driver, so that a lamp can be dimmed by switching it fully on and off at a low rate. It has three sources for that signal. The first is an internal period counter compared against a duty command. The second passes an external PWM straight through. The third rebuilds the external PWM's period and high time from measurements and replays it shifted by a programmable phase, so several controllers sharing one external PWM can spread their lamp current over the period.

An external PWM that is toggling always takes precedence over the internal counter. If it stops toggling for a timeout, the block returns to the internal counter, unless the command asks for the external source only; in that case the gate stays off. While the lamp strike sequence runs, dimming is suspended and the gate is held on. A saturating ramp value follows the gate up and down one step per cycle, so the lamp current can be scaled with soft edges.

Top module: `burst_dimmer`

## Requirements
- R1: In reset and on the first sample after reset is released, with the external PWM quiet and the external-only command applied, `burst_gate` is 0 and `cur_scale` is 0.
- R2: In internal mode, the level field `dim_cmd[DUTY_W:0]` holds a duty value L from 0 to 2^DUTY_W, and `period_cyc` is the burst period in cycles, with 0 treated as 1. Each period then has exactly floor(period_cyc*L/2^DUTY_W) on cycles. L=0 gives no on cycles and L=2^DUTY_W gives the gate on in every cycle.
- R3: After a rising edge of `ext_pwm`, the external source replaces the internal counter even when the internal duty is full. After TMO_CYC cycles without an edge, the internal counter drives the gate again.
- R4: A level field above 2^DUTY_W selects the external source only. With no external edge present, the gate then stays 0.
- R5: In synchronized mode (`dim_cmd[DUTY_W+1]`=0, external source present), `burst_gate` equals `ext_pwm` delayed by exactly 3 clock cycles.
- R6: In distributed mode (`dim_cmd[DUTY_W+1]`=1, external source present), the gate keeps the measured period P and high time H of `ext_pwm`. Once locked, its rising edge comes 4+D cycles after an input rising edge, where D = floor(P*phase_cmd/2^PH_W) spans 0 to just under 360 degrees. The gate is 0 until two input rising edges have been measured.
- R7: `cur_scale` moves one step per cycle toward 2^RAMP_W-1 while `burst_gate` is 1 and toward 0 while it is 0, and saturates at both ends. Its step follows the gate with one cycle of delay.
- R8: When `strike_act` is 1, `burst_gate` is 1 in the next cycle and stays 1, overriding every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dim_cmd | input | DUTY_W+2 | Bits [DUTY_W:0]: duty level or external-only select; bit DUTY_W+1: distributed (phase-shifted) select |
| period_cyc | input | PER_W | Internal burst period in clock cycles |
| ext_pwm | input | 1 | External PWM, asynchronous |
| phase_cmd | input | PH_W | Phase delay for distributed mode, fraction of one period |
| strike_act | input | 1 | Lamp strike in progress |
| burst_gate | output | 1 | Registered burst on/off gate |
| cur_scale | output | RAMP_W | Ramped current scale for soft burst edges |

## Verification
The two functions that can land in the same cycle are the end of the strike hold and a synchronized rising edge of the external PWM reaching the source selector. The bench holds strike while the external PWM runs in synchronized mode. It releases strike while the delayed pulse is high, so the selector switches from the hold to the pass-through in one step. Every cycle is compared against the model "strike OR input three cycles ago". A correct design shows an unbroken high level and a fall exactly three cycles after the input falls. A wrong priority, or a selector that drops the pulse on the switch-over cycle, shows up as a mismatch in that window.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [1:0] {
    SRC_INT  = 2'd0,
    SRC_SYNC = 2'd1,
    SRC_DIST = 2'd2,
    SRC_OFF  = 2'd3
  } burst_src_e;

endpackage

// File: rtl/burst_capture.sv
module burst_capture #(
  parameter int PER_W   = 16,
  parameter int TMO_CYC = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_raw,
  output logic             ext_s,
  output logic             rise,
  output logic             present,
  output logic             meas_ok,
  output logic [PER_W-1:0] per_meas,
  output logic [PER_W-1:0] high_meas
);

  localparam int IDLE_W = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(TMO_CYC - 1);
  localparam logic [IDLE_W-1:0] IDLE_ONE  = IDLE_W'(1);
  localparam logic [PER_W-1:0]  CNT_ONE   = PER_W'(1);
  localparam logic [PER_W-1:0]  CNT_MAX   = '1;

  logic              s1, s2, sd;
  logic              fall;
  logic              seen;
  logic              pres_q;
  logic [PER_W-1:0]  mcnt, hcnt;
  logic [IDLE_W-1:0] idle;

  assign ext_s   = s2;
  assign rise    = s2 & ~sd;
  assign fall    = ~s2 & sd;
  assign present = pres_q | rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1        <= 1'b0;
      s2        <= 1'b0;
      sd        <= 1'b0;
      seen      <= 1'b0;
      pres_q    <= 1'b0;
      meas_ok   <= 1'b0;
      mcnt      <= '0;
      hcnt      <= '0;
      per_meas  <= '0;
      high_meas <= '0;
      idle      <= '0;
    end else begin
      s1 <= ext_raw;
      s2 <= s1;
      sd <= s2;
      // period and high-time measurement between rising edges
      if (rise) begin
        mcnt <= CNT_ONE;
        hcnt <= CNT_ONE;
        seen <= 1'b1;
        if (seen) begin
          per_meas  <= mcnt;
          high_meas <= hcnt;
          meas_ok   <= 1'b1;
        end
      end else begin
        if (mcnt != CNT_MAX) mcnt <= mcnt + CNT_ONE;
        if (s2 && (hcnt != CNT_MAX)) hcnt <= hcnt + CNT_ONE;
      end
      // presence watchdog
      if (rise || fall) begin
        idle <= '0;
        if (rise) pres_q <= 1'b1;
      end else if (idle != IDLE_LAST) begin
        idle <= idle + IDLE_ONE;
      end else begin
        pres_q  <= 1'b0;
        seen    <= 1'b0;
        meas_ok <= 1'b0;
      end
    end
  end

  // R5
  edge_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);

  // R6
  high_le_period_chk: assert property (@(posedge clk) disable iff (rst)
    meas_ok |-> (high_meas <= per_meas));

endmodule

// File: rtl/burst_internal.sv
module burst_internal #(
  parameter int PER_W  = 16,
  parameter int DUTY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] period_cyc,
  input  logic [DUTY_W:0]  duty,
  output logic             on
);

  localparam int PROD_W = PER_W + DUTY_W + 1;
  localparam logic [PER_W-1:0] ONE = PER_W'(1);

  logic [PER_W-1:0]  per_eff;
  logic [PER_W-1:0]  ic;
  logic [PROD_W-1:0] prod;
  logic [PER_W:0]    on_cnt;

  assign per_eff = (period_cyc == '0) ? ONE : period_cyc;
  assign prod    = PROD_W'(per_eff) * PROD_W'(duty);
  assign on_cnt  = (PER_W+1)'(prod >> DUTY_W);
  assign on      = ({1'b0, ic} < on_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      ic <= '0;
    end else if (ic >= (per_eff - ONE)) begin
      ic <= '0;
    end else begin
      ic <= ic + ONE;
    end
  end

  // R2
  duty_bound_chk: assert property (@(posedge clk) disable iff (rst)
    on_cnt <= {1'b0, per_eff});

  // R2
  zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (duty == '0) |-> !on);

endmodule

// File: rtl/burst_phase.sv
module burst_phase #(
  parameter int PER_W = 16,
  parameter int PH_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic             meas_ok,
  input  logic [PER_W-1:0] per_meas,
  input  logic [PER_W-1:0] high_meas,
  input  logic [PH_W-1:0]  phase,
  output logic             on
);

  localparam int PROD_W = PER_W + PH_W;
  localparam logic [PER_W-1:0] ONE = PER_W'(1);

  logic [PER_W-1:0]  pc;
  logic [PER_W-1:0]  dly;
  logic [PROD_W-1:0] prod;
  logic [PER_W:0]    off;

  assign prod = PROD_W'(per_meas) * PROD_W'(phase);
  assign dly  = PER_W'(prod >> PH_W);

  always_comb begin
    if (pc >= dly) off = {1'b0, pc} - {1'b0, dly};
    else           off = {1'b0, pc} + {1'b0, per_meas} - {1'b0, dly};
  end

  assign on = meas_ok && (off < {1'b0, high_meas});

  // local burst oscillator, re-aligned on every external rising edge
  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else if (rise) begin
      pc <= '0;
    end else if (pc >= (per_meas - ONE)) begin
      pc <= '0;
    end else begin
      pc <= pc + ONE;
    end
  end

  // R6
  delay_range_chk: assert property (@(posedge clk) disable iff (rst)
    meas_ok |-> (dly < per_meas));

  // R6
  lock_range_chk: assert property (@(posedge clk) disable iff (rst)
    meas_ok |-> (pc < per_meas));

endmodule

// File: rtl/soft_ramp.sv
module soft_ramp #(
  parameter int RAMP_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gate,
  output logic [RAMP_W-1:0] scale
);

  localparam logic [RAMP_W-1:0] MAXV = '1;
  localparam logic [RAMP_W-1:0] ONE  = RAMP_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      scale <= '0;
    end else if (gate) begin
      if (scale != MAXV) scale <= scale + ONE;
    end else begin
      if (scale != '0) scale <= scale - ONE;
    end
  end

  // R7
  ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((scale == $past(scale)) || (scale == $past(scale) + ONE) ||
              (scale == $past(scale) - ONE)));

  // R7
  ramp_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (gate && (scale != '0)) |=> (scale != '0));

endmodule

// File: rtl/burst_dimmer.sv
module burst_dimmer #(
  parameter int PER_W   = 16,
  parameter int DUTY_W  = 8,
  parameter int PH_W    = 8,
  parameter int RAMP_W  = 6,
  parameter int TMO_CYC = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W+1:0] dim_cmd,
  input  logic [PER_W-1:0]  period_cyc,
  input  logic              ext_pwm,
  input  logic [PH_W-1:0]   phase_cmd,
  input  logic              strike_act,
  output logic              burst_gate,
  output logic [RAMP_W-1:0] cur_scale
);
  import burst_pkg::*;

  localparam logic [DUTY_W:0] FULL = (DUTY_W+1)'(1) << DUTY_W;

  logic [DUTY_W:0]  level;
  logic [DUTY_W:0]  duty_eff;
  logic             force_ext;
  logic             dist_sel;
  logic             ext_s, rise, present, meas_ok;
  logic [PER_W-1:0] per_meas, high_meas;
  logic             int_on, dist_on;
  logic             gate_d;
  burst_src_e       src;

  assign level     = dim_cmd[DUTY_W:0];
  assign dist_sel  = dim_cmd[DUTY_W+1];
  assign force_ext = (level > FULL);
  assign duty_eff  = force_ext ? FULL : level;

  burst_capture #(.PER_W(PER_W), .TMO_CYC(TMO_CYC)) u_cap (
    .clk(clk), .rst(rst), .ext_raw(ext_pwm),
    .ext_s(ext_s), .rise(rise), .present(present), .meas_ok(meas_ok),
    .per_meas(per_meas), .high_meas(high_meas)
  );

  burst_internal #(.PER_W(PER_W), .DUTY_W(DUTY_W)) u_int (
    .clk(clk), .rst(rst), .period_cyc(period_cyc), .duty(duty_eff), .on(int_on)
  );

  burst_phase #(.PER_W(PER_W), .PH_W(PH_W)) u_phs (
    .clk(clk), .rst(rst), .rise(rise), .meas_ok(meas_ok),
    .per_meas(per_meas), .high_meas(high_meas), .phase(phase_cmd), .on(dist_on)
  );

  always_comb begin
    if (present)        src = dist_sel ? SRC_DIST : SRC_SYNC;
    else if (force_ext) src = SRC_OFF;
    else                src = SRC_INT;
  end

  always_comb begin
    if (strike_act) begin
      gate_d = 1'b1;
    end else begin
      unique case (src)
        SRC_INT:  gate_d = int_on;
        SRC_SYNC: gate_d = ext_s;
        SRC_DIST: gate_d = dist_on;
        default:  gate_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) burst_gate <= 1'b0;
    else     burst_gate <= gate_d;
  end

  soft_ramp #(.RAMP_W(RAMP_W)) u_ramp (
    .clk(clk), .rst(rst), .gate(burst_gate), .scale(cur_scale)
  );

  // R8
  strike_hold_chk: assert property (@(posedge clk) disable iff (rst)
    strike_act |=> burst_gate);

  // R4
  force_off_chk: assert property (@(posedge clk) disable iff (rst)
    (force_ext && !present && !strike_act) |=> !burst_gate);

  // R3
  fallback_full_chk: assert property (@(posedge clk) disable iff (rst)
    (!present && (level == FULL) && !strike_act) |=> burst_gate);

endmodule

// File: tb/tb_burst_dimmer.sv
`timescale 1ns/1ps
module tb_burst_dimmer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] dim_cmd = 10'd257;
  logic [15:0] period_cyc = 16'd10;
  logic       ext_pwm = 1'b0;
  logic [7:0] phase_cmd = 8'd0;
  logic       strike_act = 1'b0;
  logic       burst_gate;
  logic [5:0] cur_scale;

  int   n_chk = 0;
  int   n_bad = 0;
  logic xh1 = 1'b0, xh2 = 1'b0, xh3 = 1'b0;
  logic g_s, ex3;
  logic [5:0] sc_s;

  always #2 clk = ~clk;

  burst_dimmer dut (
    .clk(clk), .rst(rst), .dim_cmd(dim_cmd), .period_cyc(period_cyc),
    .ext_pwm(ext_pwm), .phase_cmd(phase_cmd), .strike_act(strike_act),
    .burst_gate(burst_gate), .cur_scale(cur_scale)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic x);
    @(negedge clk);
    g_s  = burst_gate;
    sc_s = cur_scale;
    ex3  = xh3;
    xh3  = xh2;
    xh2  = xh1;
    xh1  = x;
    ext_pwm = x;
  endtask

  task automatic t_reset();
    repeat (3) tick(1'b0);
    check("R1 gate in reset", int'(g_s), 0);
    check("R1 scale in reset", int'(sc_s), 0);
    rst = 1'b0;
    tick(1'b0);
    check("R1 gate after reset", int'(g_s), 0);
    check("R1 scale after reset", int'(sc_s), 0);
  endtask

  task automatic t_indep(input int per, input int lvl, input int win, input int exp);
    int c = 0;
    period_cyc = 16'(per);
    dim_cmd    = 10'(lvl);
    repeat (20) tick(1'b0);
    for (int i = 0; i < win; i++) begin
      tick(1'b0);
      if (g_s) c++;
    end
    check($sformatf("R2 on cycles per=%0d lvl=%0d", per, lvl), c, exp);
  endtask

  task automatic t_force();
    int c = 0;
    dim_cmd = 10'd257;
    for (int i = 0; i < 80; i++) begin
      tick(1'b0);
      if (g_s) c++;
    end
    check("R4 external-only with no input keeps gate off", c, 0);
    check("R7 scale decayed to zero", int'(sc_s), 0);
  endtask

  task automatic t_strike_ramp();
    strike_act = 1'b1;
    tick(1'b0);
    check("R8 gate one cycle after strike", int'(g_s), 1);
    check("R7 scale lags gate by one cycle", int'(sc_s), 0);
    repeat (9) tick(1'b0);
    check("R7 scale rising one per cycle", int'(sc_s), 9);
    repeat (60) tick(1'b0);
    check("R8 gate held during strike", int'(g_s), 1);
    check("R7 scale saturates at top", int'(sc_s), 63);
    strike_act = 1'b0;
    tick(1'b0);
    check("R8 gate off after strike ends", int'(g_s), 0);
    check("R7 scale holds top for one cycle", int'(sc_s), 63);
    repeat (4) tick(1'b0);
    check("R7 scale falling one per cycle", int'(sc_s), 59);
    repeat (100) tick(1'b0);
    check("R7 scale saturates at zero", int'(sc_s), 0);
  endtask

  task automatic t_sync_strike();
    dim_cmd    = 10'd257;
    strike_act = 1'b1;
    for (int p = 0; p < 10; p++) begin
      for (int k = 0; k < 12; k++) begin
        tick(k < 5);
        if (strike_act) check("R8 strike overrides pass-through", int'(g_s), 1);
        else check("R5 gate equals input three cycles late", int'(g_s), int'(ex3));
        if (p == 4 && k == 2) strike_act = 1'b0;
      end
    end
  endtask

  task automatic t_fallback();
    dim_cmd = 10'd256;
    for (int p = 0; p < 5; p++) begin
      for (int k = 0; k < 12; k++) begin
        tick(k < 5);
        check("R3 external overrides full internal duty", int'(g_s), int'(ex3));
      end
    end
    repeat (4096 - 50) tick(1'b0);
    check("R3 external still present before timeout", int'(g_s), 0);
    repeat (100) tick(1'b0);
    check("R3 internal duty resumes after timeout", int'(g_s), 1);
  endtask

  task automatic t_dist();
    dim_cmd   = 10'h301;
    phase_cmd = 8'd64;
    for (int p = 0; p < 10; p++) begin
      if (p == 6) phase_cmd = 8'd255;
      for (int k = 0; k < 20; k++) begin
        tick(k < 6);
        if (p == 4 || p == 5)
          check($sformatf("R6 phase 64 k=%0d", k), int'(g_s), int'(k >= 9 && k <= 14));
        if (p == 8 || p == 9)
          check($sformatf("R6 phase 255 k=%0d", k), int'(g_s), int'(k >= 3 && k <= 8));
      end
    end
  endtask

  initial begin
    #800000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_indep(10, 128, 100, 50);
    t_indep(16, 64, 160, 40);
    t_indep(7, 100, 70, 20);
    t_indep(10, 0, 100, 0);
    t_indep(10, 256, 100, 100);
    t_force();
    t_strike_ramp();
    t_sync_strike();
    t_fallback();
    t_dist();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule